// File: doc/BRIEF.md
# Error-Correcting Word Memory with Write-Path Fault Injection

This block is a word-addressed storage array protected by a single-error-correcting, double-error-detecting code. Every stored word holds 32 data bits and 7 check bits. One request port carries both reads and writes. A write may cover the whole word or only some byte lanes. A write that covers only some lanes is done as read-modify-write: the stored word is first checked and corrected, then the new bytes are merged in, and the result is written back with fresh check bits. An error that is already in the word is therefore reported during the write.

Two injection registers allow self-test software to corrupt the next committed write. One register is a 32-bit data flip mask. The other is a 7-bit check flip mask, whose bits stand for the injection positions from 32 upward. Each checked access reports its result in the cycle after the request. The result is a correctable or uncorrectable error pulse, together with the failing address and the raw stored data and check bits. A separate status block collects these reports. A control input turns checking off, so that a pass of reads and write-backs can set up valid check bits in a memory that was never written.

Top module: `ecc_fi_mem`

## Requirements
- R1: After reset, `rd_valid`, `err_ce` and `err_ue` are low and both injection masks are clear, so the first write stores a clean word.
- R2: A read request raises `rd_valid` for exactly one cycle, in the cycle after the request, with the word's data on `rd_data`. `rd_valid`, `err_ce` and `err_ue` stay low in any cycle that follows a cycle without a request.
- R3: The check field is laid out as follows. Data bit i takes the i-th codeword position, counting upward from 3 and skipping powers of two. Check bit k (k = 0..5) is the parity of the data bits whose position has bit k set. Check bit 6 is the parity of all 32 data bits and check bits 0..5.
- R4: A committed write stores its data XOR the data flip mask, and the code of that data XOR the check flip mask. Check-mask bit j stands for injection position 32+j.
- R5: Both masks return to zero after the first committed write that follows their loading, so later writes are clean. A mask load in the same cycle as a write takes effect after that write.
- R6: When exactly one stored bit differs from the clean codeword, whether a data bit or a check bit, a read pulses `err_ce` and returns the corrected data. `err_addr`, `err_data` and `err_chk` show the address and the raw stored bits.
- R7: When two stored bits differ, a read pulses `err_ue` and returns the raw data. `err_addr`, `err_data` and `err_chk` show the address and the raw stored bits.
- R8: In a write with some, but not all, of `req_be` set, enable bit b selects data bits 8b+7..8b. The other bytes come from the corrected stored word. A single-bit error in that word raises `err_ce`, with raw fields, in the cycle after the write, and the word is stored clean.
- R9: A partial write to a word that holds an uncorrectable error raises `err_ue` and leaves the stored word and both armed masks unchanged.
- R10: A full-word write (all of `req_be` set) never raises `err_ce` or `err_ue`.
- R11: While `ecc_on` is low, nothing is corrected or flagged: reads return raw data, and partial writes merge into the raw stored data. Every write still stores proper check bits, so reading a word and writing it back makes it clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_on | input | 1 | Checking and correction enable |
| inj_data_we | input | 1 | Load the data flip mask |
| inj_data_in | input | 32 | New data flip mask |
| inj_chk_we | input | 1 | Load the check flip mask |
| inj_chk_in | input | 7 | New check flip mask |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address |
| req_be | input | 4 | Byte lane enables for writes |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data (corrected when possible) |
| err_ce | output | 1 | Correctable error pulse |
| err_ue | output | 1 | Uncorrectable error pulse |
| err_addr | output | 6 | Address of the last failing access |
| err_data | output | 32 | Raw stored data of the last failing access |
| err_chk | output | 7 | Raw stored check bits of the last failing access |

## Verification
Every result of this block is due in the cycle right after the request's clock edge. This holds for read data, for both error pulses and for the captured failing fields, whether the request is a read or a partial write. Writes themselves take effect at that same edge, so a read in the next cycle sees the new word. The driver task pushes one expected item for each request as it drives that request. The monitor notes at each rising edge whether a request was present, then samples 2 ns later and pops exactly one item to compare. Cycles after idle edges are checked for the absence of any pulse.

// File: rtl/ecc_fi_pkg.sv
package ecc_fi_pkg;

   // number of Hamming check bits needed to cover dw data bits
   function automatic int ham_bits(input int dw);
      int p;
      p = 0;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ecc_fi_enc.sv
module ecc_fi_enc #(
   parameter int DATA_W = 32,
   parameter int HAM_W  = ecc_fi_pkg::ham_bits(DATA_W),
   parameter int CHK_W  = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);
   localparam int CW_N = DATA_W + HAM_W;

   logic [HAM_W-1:0] ham;

   always_comb begin
      int di;
      di  = 0;
      ham = '0;
      for (int pos = 1; pos <= CW_N; pos++) begin
         if (!ecc_fi_pkg::is_pow2(pos)) begin
            if (data[di]) ham = ham ^ HAM_W'(pos);
            di++;
         end
      end
   end

   assign chk = {(^data) ^ (^ham), ham};
endmodule

// File: rtl/ecc_fi_dec.sv
module ecc_fi_dec #(
   parameter int DATA_W = 32,
   parameter int HAM_W  = ecc_fi_pkg::ham_bits(DATA_W),
   parameter int CHK_W  = HAM_W + 1
) (
   input  logic [DATA_W-1:0] data,
   input  logic [CHK_W-1:0]  chk,
   output logic [DATA_W-1:0] cdata,
   output logic              ce,
   output logic              ue
);
   localparam int CW_N = DATA_W + HAM_W;

   logic [CHK_W-1:0] recalc;
   logic [HAM_W-1:0] syn;
   logic             par;

   ecc_fi_enc #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CHK_W(CHK_W)) u_renc (
      .data (data),
      .chk  (recalc)
   );

   assign syn = recalc[HAM_W-1:0] ^ chk[HAM_W-1:0];
   assign par = (^data) ^ (^chk);

   always_comb begin
      int di;
      di    = 0;
      cdata = data;
      ce    = 1'b0;
      ue    = 1'b0;
      if (par) begin
         if (int'(syn) > CW_N) begin
            ue = 1'b1;
         end else begin
            ce = 1'b1;
            for (int pos = 1; pos <= CW_N; pos++) begin
               if (!ecc_fi_pkg::is_pow2(pos)) begin
                  if (int'(syn) == pos) cdata[di] = ~cdata[di];
                  di++;
               end
            end
         end
      end else if (syn != '0) begin
         ue = 1'b1;
      end
   end
endmodule

// File: rtl/ecc_fi_store.sv
module ecc_fi_store #(
   parameter int WORD_W = 39,
   parameter int DEPTH  = 64,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wword,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rword
);
   logic [WORD_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wword;
   end

   assign rword = cells[raddr];
endmodule

// File: rtl/ecc_fi_mem.sv
module ecc_fi_mem #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 64,
   parameter int ADDR_W = $clog2(DEPTH),
   parameter int HAM_W  = ecc_fi_pkg::ham_bits(DATA_W),
   parameter int CHK_W  = HAM_W + 1,
   parameter int BE_W   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ecc_on,
   input  logic              inj_data_we,
   input  logic [DATA_W-1:0] inj_data_in,
   input  logic              inj_chk_we,
   input  logic [CHK_W-1:0]  inj_chk_in,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              err_ce,
   output logic              err_ue,
   output logic [ADDR_W-1:0] err_addr,
   output logic [DATA_W-1:0] err_data,
   output logic [CHK_W-1:0]  err_chk
);
   localparam int WORD_W = DATA_W + CHK_W;

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 8");
   end
   if (DEPTH < 2 || (1 << ADDR_W) < DEPTH) begin : g_bad_depth
      $error("DEPTH must be at least 2 and fit in ADDR_W");
   end
   if (BE_W * 8 != DATA_W) begin : g_bad_be
      $error("BE_W must equal DATA_W / 8");
   end

   logic [DATA_W-1:0] dmask_q;
   logic [CHK_W-1:0]  cmask_q;

   logic [WORD_W-1:0] raw_word;
   logic [DATA_W-1:0] raw_d, fix_d, merge_src, merged;
   logic [CHK_W-1:0]  raw_c, new_c;
   logic              dec_ce, dec_ue;
   logic              is_full, checked, commit;

   ecc_fi_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
      .clk   (clk),
      .we    (commit),
      .waddr (req_addr),
      .wword ({new_c ^ cmask_q, merged ^ dmask_q}),
      .raddr (req_addr),
      .rword (raw_word)
   );

   assign raw_d = raw_word[DATA_W-1:0];
   assign raw_c = raw_word[WORD_W-1:DATA_W];

   ecc_fi_dec #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CHK_W(CHK_W)) u_dec (
      .data  (raw_d),
      .chk   (raw_c),
      .cdata (fix_d),
      .ce    (dec_ce),
      .ue    (dec_ue)
   );

   assign is_full   = &req_be;
   assign checked   = req_valid && ecc_on && (!req_write || !is_full);
   assign merge_src = ecc_on ? fix_d : raw_d;
   assign commit    = req_valid && req_write && !(checked && dec_ue);

   for (genvar b = 0; b < BE_W; b++) begin : g_lane
      assign merged[b*8 +: 8] = req_be[b] ? req_wdata[b*8 +: 8] : merge_src[b*8 +: 8];
   end

   ecc_fi_enc #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CHK_W(CHK_W)) u_wenc (
      .data (merged),
      .chk  (new_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dmask_q  <= '0;
         cmask_q  <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
         err_ce   <= 1'b0;
         err_ue   <= 1'b0;
         err_addr <= '0;
         err_data <= '0;
         err_chk  <= '0;
      end else begin
         if (commit) begin
            dmask_q <= '0;
            cmask_q <= '0;
         end
         if (inj_data_we) dmask_q <= inj_data_in;
         if (inj_chk_we)  cmask_q <= inj_chk_in;

         rd_valid <= req_valid && !req_write;
         if (req_valid && !req_write) rd_data <= ecc_on ? fix_d : raw_d;

         err_ce <= checked && dec_ce;
         err_ue <= checked && dec_ue;
         if (checked && (dec_ce || dec_ue)) begin
            err_addr <= req_addr;
            err_data <= raw_d;
            err_chk  <= raw_c;
         end
      end
   end

   // R6/R7: a word is never both correctable and uncorrectable
   a_r7_ce_ue_excl: assert property (@(posedge clk) disable iff (!rst_n)
      err_ce |-> !err_ue);

   a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid);

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rd_valid && !err_ce && !err_ue));

   a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !ecc_on) |=> (!err_ce && !err_ue));

   a_r10_full_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && (&req_be)) |=> (!err_ce && !err_ue));

   a_r5_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && (&req_be) && !inj_data_we && !inj_chk_we)
      |=> (dmask_q == '0 && cmask_q == '0));

   a_r9_ue_keeps_masks: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ue && !$past(req_write && (&req_be)) && !$past(inj_data_we))
      |-> $stable(dmask_q));
endmodule

// File: tb/sim_ecc_fi_mem.sv
`timescale 1ns/1ps
module sim_ecc_fi_mem;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ecc_on = 1'b1;
   logic        inj_data_we = 1'b0;
   logic [31:0] inj_data_in = '0;
   logic        inj_chk_we = 1'b0;
   logic [6:0]  inj_chk_in = '0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [5:0]  req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        rd_valid, err_ce, err_ue;
   logic [31:0] rd_data, err_data;
   logic [5:0]  err_addr;
   logic [6:0]  err_chk;

   always #4 clk = ~clk;

   ecc_fi_mem u0 (
      .clk(clk), .rst_n(rst_n), .ecc_on(ecc_on),
      .inj_data_we(inj_data_we), .inj_data_in(inj_data_in),
      .inj_chk_we(inj_chk_we), .inj_chk_in(inj_chk_in),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_be(req_be), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .err_ce(err_ce), .err_ue(err_ue),
      .err_addr(err_addr), .err_data(err_data), .err_chk(err_chk)
   );

   typedef struct {
      bit          rd;
      logic [31:0] rdat;
      bit          ce;
      bit          ue;
      logic [5:0]  ad;
      logic [31:0] ed;
      logic [6:0]  ec;
      string       tag;
   } exp_t;

   exp_t        q[$];
   int          n_tests = 0;
   int          n_fail  = 0;
   logic [31:0] m_raw_d [64];
   logic [6:0]  m_raw_c [64];
   logic [31:0] m_good  [64];
   logic [31:0] dm = '0;
   logic [6:0]  cm = '0;
   bit          ecc = 1'b1;

   // R3: check bits from the position of each set data bit
   function automatic logic [6:0] code_of(input logic [31:0] d);
      logic [5:0] h;
      int pos;
      h = '0;
      pos = 2;
      for (int b = 0; b < 32; b++) begin
         pos++;
         while ((pos & (pos - 1)) == 0) pos++;
         if (d[b]) h = h ^ pos[5:0];
      end
      return {(^d) ^ (^h), h};
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int flips(input int a);
      return $countones(m_raw_d[a] ^ m_good[a]) + $countones(m_raw_c[a] ^ code_of(m_good[a]));
   endfunction

   task automatic load_masks(input logic [31:0] d, input logic [6:0] c);
      inj_data_we = 1'b1; inj_data_in = d;
      inj_chk_we  = 1'b1; inj_chk_in  = c;
      dm = d; cm = c;
      @(negedge clk);
      inj_data_we = 1'b0; inj_chk_we = 1'b0;
   endtask

   task automatic set_ecc(input bit v);
      ecc = v; ecc_on = v;
   endtask

   task automatic wr(input int a, input logic [3:0] be, input logic [31:0] wd, input string tag);
      exp_t e;
      int n;
      bit part;
      logic [31:0] src, mg;
      part = (be != 4'hF);
      n = flips(a);
      e.rd = 1'b0; e.rdat = '0;
      e.ce = ecc && part && (n == 1);
      e.ue = ecc && part && (n >= 2);
      e.ad = a[5:0]; e.ed = m_raw_d[a]; e.ec = m_raw_c[a]; e.tag = tag;
      if (!e.ue) begin
         src = ecc ? m_good[a] : m_raw_d[a];
         for (int b = 0; b < 4; b++) mg[b*8 +: 8] = be[b] ? wd[b*8 +: 8] : src[b*8 +: 8];
         m_raw_d[a] = mg ^ dm;
         m_raw_c[a] = code_of(mg) ^ cm;
         m_good[a]  = mg;
         dm = '0; cm = '0;
      end
      q.push_back(e);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a[5:0]; req_be = be; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input int a, input string tag);
      exp_t e;
      int n;
      n = flips(a);
      e.rd = 1'b1;
      e.ce = ecc && (n == 1);
      e.ue = ecc && (n >= 2);
      e.rdat = (ecc && n <= 1) ? m_good[a] : m_raw_d[a];
      e.ad = a[5:0]; e.ed = m_raw_d[a]; e.ec = m_raw_c[a]; e.tag = tag;
      q.push_back(e);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a[5:0]; req_be = '0;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: results are due in the cycle after the request edge
   initial begin
      forever begin
         bit issued;
         exp_t e;
         @(posedge clk);
         issued = (req_valid === 1'b1);
         #2;
         if (issued && q.size() > 0) begin
            e = q.pop_front();
            chk(e.tag, "rd_valid", 64'(rd_valid), 64'(e.rd));
            if (e.rd) chk(e.tag, "rd_data", 64'(rd_data), 64'(e.rdat));
            chk(e.tag, "err_ce", 64'(err_ce), 64'(e.ce));
            chk(e.tag, "err_ue", 64'(err_ue), 64'(e.ue));
            if (e.ce || e.ue) begin
               chk(e.tag, "err_addr", 64'(err_addr), 64'(e.ad));
               chk(e.tag, "err_data", 64'(err_data), 64'(e.ed));
               chk(e.tag, "err_chk", 64'(err_chk), 64'(e.ec));
            end
         end else if (rst_n && (rd_valid || err_ce || err_ue)) begin
            n_fail++;
            $display("FAIL R2 idle pulse actual=%0b%0b%0b expected=000", rd_valid, err_ce, err_ue);
         end
      end
   end

   initial begin
      #(8 * 100000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         m_raw_d[i] = '0; m_raw_c[i] = '0; m_good[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1", "rd_valid", 64'(rd_valid), 64'd0);
      chk("R1", "err_ce", 64'(err_ce), 64'd0);
      chk("R1", "err_ue", 64'(err_ue), 64'd0);

      // R1/R2: clean first writes, back-to-back reads
      wr(0, 4'hF, 32'hA5A5_3C3C, "R1");
      rd(0, "R1");
      wr(63, 4'hF, 32'hFFFF_FFFF, "R2");
      wr(1, 4'hF, 32'h0000_0000, "R2");
      rd(63, "R2");
      rd(1, "R2");
      @(negedge clk);

      // R4/R6/R3: single data flips
      load_masks(32'h0000_0001, 7'h00);
      wr(2, 4'hF, 32'h1234_5678, "R4");
      rd(2, "R6_data0");
      wr(3, 4'hF, 32'hCAFE_F00D, "R5");
      rd(3, "R5");
      load_masks(32'h8000_0000, 7'h00);
      wr(4, 4'hF, 32'h0F0F_1234, "R6");
      rd(4, "R6_data31");
      // single check flips: overall parity bit and a Hamming bit
      load_masks(32'h0, 7'h40);
      wr(5, 4'hF, 32'h7654_3210, "R3");
      rd(5, "R6_chk6");
      load_masks(32'h0, 7'h04);
      wr(6, 4'hF, 32'hDEAD_BEEF, "R3");
      rd(6, "R6_chk2");

      // R7: double flips
      load_masks(32'h0002_0008, 7'h00);
      wr(7, 4'hF, 32'h5555_AAAA, "R7");
      rd(7, "R7_dd");
      load_masks(32'h0000_0200, 7'h10);
      wr(8, 4'hF, 32'h1357_9BDF, "R7");
      rd(8, "R7_dc");
      load_masks(32'h0, 7'h41);
      wr(9, 4'hF, 32'h2468_ACE0, "R7");
      rd(9, "R7_cc");

      // R8: partial writes
      wr(10, 4'hF, 32'h1111_2222, "R8");
      wr(10, 4'b0010, 32'h0000_AB00, "R8_byte");
      rd(10, "R8");
      load_masks(32'h0010_0000, 7'h00);
      wr(11, 4'hF, 32'h89AB_CDEF, "R8");
      wr(11, 4'b0011, 32'h0000_5A5A, "R8_half_ce");
      rd(11, "R8_clean");

      // R9: partial write over an uncorrectable word is dropped
      load_masks(32'h0000_0020, 7'h00);
      wr(7, 4'b0100, 32'h00CC_0000, "R9_ue");
      rd(7, "R9_kept");
      wr(12, 4'hF, 32'h0BAD_CAFE, "R9_armed");
      rd(12, "R9_armed");

      // R10: full write over a damaged word raises nothing
      wr(8, 4'hF, 32'h0123_4567, "R10");
      rd(8, "R10");

      // R11: checking off, then read/write-back initialises the code
      set_ecc(1'b0);
      @(negedge clk);
      rd(7, "R11_raw");
      wr(7, 4'hF, m_raw_d[7], "R11");
      wr(9, 4'b1000, 32'h7700_0000, "R11_merge");
      set_ecc(1'b1);
      @(negedge clk);
      rd(7, "R11_init");
      rd(9, "R11_init");

      repeat (3) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule